// File: doc/BRIEF.md
# Network Message Queue Receiver

This block sits between a node's network port and its local memory. Each incoming packet carries four data words and the number of the node it is meant for. The block takes one packet at a time, chooses a slot in a circular message queue held in memory, writes the four words to consecutive addresses there, and then tells the sender through a one-cycle response whether the packet was taken or refused. Packets for another node, and packets that find the queue full, are refused without touching memory.

The queue has a normal region of `NORM_SLOTS` slots and a small spare region of `OVF_SLOTS` slots after it. The spare region is kept for error reports raised by local support logic: such a packet goes to the normal region while it has room and to the spare region once the normal region is full. Software owns the head of the queue and moves it by writing a new head index. The block keeps the tail, the occupancy, a configurable limit and an interrupt threshold. Every stored message raises a message interrupt that the processor clears with an acknowledge. Crossing the threshold sets a sticky signal bit that software clears by a write.

Slot `s`, word `k` lives at word address `BASE_ADDR + s*MSG_WORDS + k`. Spare slot `j` is slot `NORM_SLOTS + j`.

Top module: `mq_receiver`

## Requirements
- R1: After reset `pkt_ready` is 1, `mem_we`, `resp_valid`, `msg_irq` and `sig_o` are 0, and `tail_o`, `occ_o` and `ovf_used_o` are 0. The limit resets to `NORM_SLOTS` and the threshold resets to `THRESH_RST`.
- R2: A packet is taken on a clock edge where `pkt_valid` and `pkt_ready` are both 1. If it is stored, word `k` (bits `k*DATA_W` and up of `pkt_data`) is written with `mem_we` high in the (k+1)-th cycle after that edge, at address `BASE_ADDR + slot*MSG_WORDS + k`. `pkt_ready` is 0 while these writes run.
- R3: A packet stored in the normal region uses slot `tail_o`. The tail advances by one on the edge that ends the last word write, and after slot `NORM_SLOTS-1` it returns to 0.
- R4: A stored packet gets `resp_valid`=1 with `resp_nack`=0 in the cycle after its last word write. A refused packet gets `resp_valid`=1 with `resp_nack`=1 in the cycle after it is taken, and nothing is written to memory.
- R5: A packet whose `pkt_node` differs from `node_id` is refused.
- R6: A packet with `pkt_err`=0 is refused when the occupancy is at or above the limit, and the tail and occupancy then stay unchanged.
- R7: A packet with `pkt_err`=1 that finds the normal region at its limit is stored in spare slot `ovf_used_o`, and `ovf_used_o` then rises by one. It is refused once all `OVF_SLOTS` spare slots are in use. A pulse on `ovf_release` returns `ovf_used_o` to 0, or to 1 if a spare store completes on the same edge.
- R8: `occ_o` rises by one for each normal-region store. On a head write it falls by (new head - old head) modulo `NORM_SLOTS`. Both changes apply together when they fall on the same edge.
- R9: When a normal-region store leaves the occupancy at or above a nonzero threshold, `sig_o` is set. It stays set until a `sig_clr` pulse. If a set and a clear fall on the same edge, the set wins.
- R10: Every stored packet, in either region, sets `msg_irq`. A `proc_ack` pulse clears it, and a store on the same edge wins over the acknowledge.
- R11: A `cfg_we` pulse loads the limit and the threshold for use from the next cycle on. A limit above `NORM_SLOTS` is taken as `NORM_SLOTS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | NODE_W | Number of this node |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Block can take a packet |
| pkt_node | input | NODE_W | Destination node of the packet |
| pkt_err | input | 1 | Packet is a local error report |
| pkt_data | input | DATA_W*MSG_WORDS | Packet words, word 0 in the low bits |
| resp_valid | output | 1 | Response to the sender is present |
| resp_nack | output | 1 | Response is a refusal |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| head_we | input | 1 | Software head write |
| head_wdata | input | clog2(NORM_SLOTS) | New head index |
| cfg_we | input | 1 | Limit and threshold write |
| cfg_limit | input | clog2(NORM_SLOTS+1) | New limit |
| cfg_thresh | input | clog2(NORM_SLOTS+1) | New threshold, 0 disables |
| sig_clr | input | 1 | Clears the signal bit |
| proc_ack | input | 1 | Processor acknowledge, clears the message interrupt |
| ovf_release | input | 1 | Frees all spare slots |
| msg_irq | output | 1 | Message interrupt |
| sig_o | output | 1 | Sticky threshold signal bit |
| tail_o | output | clog2(NORM_SLOTS) | Tail index |
| occ_o | output | clog2(NORM_SLOTS+1) | Normal-region occupancy |
| ovf_used_o | output | clog2(OVF_SLOTS+1) | Spare slots in use |

## Verification
The functions that can meet on one edge are a store completing and a software write to the same state. A head write on the edge that ends a store has to subtract the freed slots and add the new one at once. A signal-bit clear or an interrupt acknowledge on that edge has to lose to the set. The bench watches for the third word of a packet on the memory port and drives the software strobe for exactly the following cycle, so that the strobe lands on the closing edge. The behavioural model applies both effects on that edge, and its occupancy, signal bit and interrupt are compared with the ports in the cycle after.

// File: rtl/mq_pkg.sv
package mq_pkg;

   // Where an accepted packet is placed.
   typedef enum logic [1:0] {
      SLOT_NONE     = 2'd0,
      SLOT_NORMAL   = 2'd1,
      SLOT_OVERFLOW = 2'd2
   } slot_kind_e;

   // Writer sequencing state.
   typedef enum logic {
      WR_IDLE = 1'b0,
      WR_BUSY = 1'b1
   } wr_state_e;

endpackage

// File: rtl/mq_alloc.sv
module mq_alloc
   import mq_pkg::*;
#(
   parameter int NORM_SLOTS = 4080,
   parameter int OVF_SLOTS  = 16,
   parameter int NORM_W     = 12,
   parameter int OCC_W      = 12,
   parameter int OVF_CW     = 5,
   parameter int SLOT_W     = 12
) (
   input  logic              node_match,
   input  logic              is_err,
   input  logic [OCC_W-1:0]  occ,
   input  logic [OCC_W-1:0]  limit,
   input  logic [OVF_CW-1:0] ovf_used,
   input  logic [NORM_W-1:0] tail,
   output slot_kind_e        kind,
   output logic [SLOT_W-1:0] slot
);

   logic              room_normal;
   logic              spare_ok;
   logic [SLOT_W-1:0] spare_slot;

   assign room_normal = (occ < limit);

   generate
      if (OVF_SLOTS > 0) begin : g_spare
         assign spare_ok   = is_err && (ovf_used < OVF_CW'(OVF_SLOTS));
         assign spare_slot = SLOT_W'(NORM_SLOTS) + SLOT_W'(ovf_used);
      end else begin : g_no_spare
         assign spare_ok   = 1'b0;
         assign spare_slot = '0;
      end
   endgenerate

   always_comb begin
      kind = SLOT_NONE;
      slot = '0;
      if (node_match) begin
         if (room_normal) begin
            kind = SLOT_NORMAL;
            slot = SLOT_W'(tail);
         end else if (spare_ok) begin
            kind = SLOT_OVERFLOW;
            slot = spare_slot;
         end
      end
   end

endmodule

// File: rtl/mq_writer.sv
module mq_writer
   import mq_pkg::*;
#(
   parameter int          DATA_W    = 64,
   parameter int          MSG_WORDS = 4,
   parameter int          SLOT_W    = 12,
   parameter int          MEM_AW    = 16,
   parameter int unsigned BASE_ADDR = 0,
   localparam int         BEAT_W    = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1,
   localparam int         PKT_W     = DATA_W * MSG_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [PKT_W-1:0]  pkt_data,
   input  slot_kind_e        alloc_kind,
   input  logic [SLOT_W-1:0] alloc_slot,
   output logic              pkt_ready,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              commit_norm,
   output logic              commit_ovf,
   output logic              resp_valid,
   output logic              resp_nack
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(MSG_WORDS - 1);

   wr_state_e         st_q;
   logic [BEAT_W-1:0] beat_q;
   logic [SLOT_W-1:0] slot_q;
   slot_kind_e        kind_q;
   logic [DATA_W-1:0] word_q [MSG_WORDS];
   logic              take;
   logic              last;

   assign pkt_ready = (st_q == WR_IDLE);
   assign take      = pkt_valid && pkt_ready;
   assign last      = (st_q == WR_BUSY) && (beat_q == LAST_BEAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= WR_IDLE;
         beat_q     <= '0;
         slot_q     <= '0;
         kind_q     <= SLOT_NONE;
         resp_valid <= 1'b0;
         resp_nack  <= 1'b0;
      end else begin
         resp_valid <= 1'b0;
         resp_nack  <= 1'b0;
         if (take) begin
            if (alloc_kind == SLOT_NONE) begin
               resp_valid <= 1'b1;
               resp_nack  <= 1'b1;
            end else begin
               st_q   <= WR_BUSY;
               beat_q <= '0;
               slot_q <= alloc_slot;
               kind_q <= alloc_kind;
            end
         end else if (st_q == WR_BUSY) begin
            if (last) begin
               st_q       <= WR_IDLE;
               resp_valid <= 1'b1;
            end else begin
               beat_q <= beat_q + 1'b1;
            end
         end
      end
   end

   // Packet words are captured once, on the accepting edge.
   always_ff @(posedge clk) begin
      if (take && (alloc_kind != SLOT_NONE)) begin
         for (int w = 0; w < MSG_WORDS; w++) begin
            word_q[w] <= pkt_data[w*DATA_W +: DATA_W];
         end
      end
   end

   assign mem_we      = (st_q == WR_BUSY);
   assign mem_addr    = MEM_AW'(BASE_ADDR)
                      + MEM_AW'(slot_q) * MEM_AW'(MSG_WORDS)
                      + MEM_AW'(beat_q);
   assign mem_wdata   = word_q[beat_q];
   assign commit_norm = last && (kind_q == SLOT_NORMAL);
   assign commit_ovf  = last && (kind_q == SLOT_OVERFLOW);

endmodule

// File: rtl/mq_qstate.sv
module mq_qstate #(
   parameter int NORM_SLOTS = 4080,
   parameter int OVF_SLOTS  = 16,
   parameter int NORM_W     = 12,
   parameter int OCC_W      = 12,
   parameter int OVF_CW     = 5,
   parameter int THRESH_RST = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_norm,
   input  logic              commit_ovf,
   input  logic              head_we,
   input  logic [NORM_W-1:0] head_wdata,
   input  logic              cfg_we,
   input  logic [OCC_W-1:0]  cfg_limit,
   input  logic [OCC_W-1:0]  cfg_thresh,
   input  logic              sig_clr,
   input  logic              proc_ack,
   input  logic              ovf_release,
   output logic [NORM_W-1:0] tail,
   output logic [OCC_W-1:0]  occ,
   output logic [OCC_W-1:0]  limit,
   output logic [OVF_CW-1:0] ovf_used,
   output logic              sig,
   output logic              irq
);

   localparam logic [NORM_W-1:0] LAST_IDX = NORM_W'(NORM_SLOTS - 1);
   localparam logic [OCC_W-1:0]  CAP      = OCC_W'(NORM_SLOTS);

   logic [NORM_W-1:0] tail_q, head_q;
   logic [OCC_W-1:0]  occ_q, limit_q, thresh_q;
   logic [OVF_CW-1:0] ovf_q;
   logic              sig_q, irq_q;

   logic [NORM_W:0]   span;
   logic [OCC_W-1:0]  freed;
   logic [OCC_W-1:0]  occ_next;
   logic              sig_set;

   // Slots released by a head write, modulo the normal region size.
   always_comb begin
      if (head_wdata >= head_q) begin
         span = {1'b0, head_wdata} - {1'b0, head_q};
      end else begin
         span = {1'b0, head_wdata} + (NORM_W+1)'(NORM_SLOTS) - {1'b0, head_q};
      end
      freed = head_we ? OCC_W'(span) : '0;
   end

   assign occ_next = occ_q - freed + OCC_W'(commit_norm);
   assign sig_set  = commit_norm && (thresh_q != '0) && (occ_next >= thresh_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail_q   <= '0;
         head_q   <= '0;
         occ_q    <= '0;
         limit_q  <= CAP;
         thresh_q <= OCC_W'(THRESH_RST);
         ovf_q    <= '0;
         sig_q    <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         occ_q <= occ_next;
         if (commit_norm) begin
            tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
         end
         if (head_we) begin
            head_q <= head_wdata;
         end
         if (cfg_we) begin
            limit_q  <= (cfg_limit > CAP) ? CAP : cfg_limit;
            thresh_q <= cfg_thresh;
         end
         ovf_q <= (ovf_release ? '0 : ovf_q) + OVF_CW'(commit_ovf);
         if (sig_set) begin
            sig_q <= 1'b1;
         end else if (sig_clr) begin
            sig_q <= 1'b0;
         end
         if (commit_norm || commit_ovf) begin
            irq_q <= 1'b1;
         end else if (proc_ack) begin
            irq_q <= 1'b0;
         end
      end
   end

   assign tail     = tail_q;
   assign occ      = occ_q;
   assign limit    = limit_q;
   assign ovf_used = ovf_q;
   assign sig      = sig_q;
   assign irq      = irq_q;

endmodule

// File: rtl/mq_receiver.sv
module mq_receiver
   import mq_pkg::*;
#(
   parameter int          DATA_W     = 64,
   parameter int          MSG_WORDS  = 4,
   parameter int          NORM_SLOTS = 4080,
   parameter int          OVF_SLOTS  = 16,
   parameter int          NODE_W     = 11,
   parameter int          MEM_AW     = 16,
   parameter int unsigned BASE_ADDR  = 0,
   parameter int          THRESH_RST = 0,
   localparam int         NORM_W     = $clog2(NORM_SLOTS),
   localparam int         OCC_W      = $clog2(NORM_SLOTS + 1),
   localparam int         OVF_CW     = (OVF_SLOTS > 0) ? $clog2(OVF_SLOTS + 1) : 1,
   localparam int         SLOT_W     = $clog2(NORM_SLOTS + OVF_SLOTS),
   localparam int         PKT_W      = DATA_W * MSG_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NODE_W-1:0] node_id,
   input  logic              pkt_valid,
   output logic              pkt_ready,
   input  logic [NODE_W-1:0] pkt_node,
   input  logic              pkt_err,
   input  logic [PKT_W-1:0]  pkt_data,
   output logic              resp_valid,
   output logic              resp_nack,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              head_we,
   input  logic [NORM_W-1:0] head_wdata,
   input  logic              cfg_we,
   input  logic [OCC_W-1:0]  cfg_limit,
   input  logic [OCC_W-1:0]  cfg_thresh,
   input  logic              sig_clr,
   input  logic              proc_ack,
   input  logic              ovf_release,
   output logic              msg_irq,
   output logic              sig_o,
   output logic [NORM_W-1:0] tail_o,
   output logic [OCC_W-1:0]  occ_o,
   output logic [OVF_CW-1:0] ovf_used_o
);

   // Elaboration-time parameter checks.
   generate
      if (NORM_SLOTS < 2) begin : g_bad_norm
         $error("mq_receiver: NORM_SLOTS must be at least 2");
      end
      if (OVF_SLOTS < 0) begin : g_bad_ovf
         $error("mq_receiver: OVF_SLOTS must not be negative");
      end
      if (MSG_WORDS < 1 || DATA_W < 1) begin : g_bad_msg
         $error("mq_receiver: message shape must be non-empty");
      end
      if (longint'(BASE_ADDR) + longint'(NORM_SLOTS + OVF_SLOTS) * MSG_WORDS
          > (longint'(1) << MEM_AW)) begin : g_bad_span
         $error("mq_receiver: queue does not fit in MEM_AW address bits");
      end
      if (THRESH_RST > NORM_SLOTS) begin : g_bad_thresh
         $error("mq_receiver: THRESH_RST exceeds NORM_SLOTS");
      end
   endgenerate

   slot_kind_e        alloc_kind;
   logic [SLOT_W-1:0] alloc_slot;
   logic              commit_norm, commit_ovf;
   logic [OCC_W-1:0]  limit_cur;

   mq_alloc #(
      .NORM_SLOTS (NORM_SLOTS),
      .OVF_SLOTS  (OVF_SLOTS),
      .NORM_W     (NORM_W),
      .OCC_W      (OCC_W),
      .OVF_CW     (OVF_CW),
      .SLOT_W     (SLOT_W)
   ) u_alloc (
      .node_match (pkt_node == node_id),
      .is_err     (pkt_err),
      .occ        (occ_o),
      .limit      (limit_cur),
      .ovf_used   (ovf_used_o),
      .tail       (tail_o),
      .kind       (alloc_kind),
      .slot       (alloc_slot)
   );

   mq_writer #(
      .DATA_W    (DATA_W),
      .MSG_WORDS (MSG_WORDS),
      .SLOT_W    (SLOT_W),
      .MEM_AW    (MEM_AW),
      .BASE_ADDR (BASE_ADDR)
   ) u_writer (
      .clk         (clk),
      .rst_n       (rst_n),
      .pkt_valid   (pkt_valid),
      .pkt_data    (pkt_data),
      .alloc_kind  (alloc_kind),
      .alloc_slot  (alloc_slot),
      .pkt_ready   (pkt_ready),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .commit_norm (commit_norm),
      .commit_ovf  (commit_ovf),
      .resp_valid  (resp_valid),
      .resp_nack   (resp_nack)
   );

   mq_qstate #(
      .NORM_SLOTS (NORM_SLOTS),
      .OVF_SLOTS  (OVF_SLOTS),
      .NORM_W     (NORM_W),
      .OCC_W      (OCC_W),
      .OVF_CW     (OVF_CW),
      .THRESH_RST (THRESH_RST)
   ) u_qstate (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_norm (commit_norm),
      .commit_ovf  (commit_ovf),
      .head_we     (head_we),
      .head_wdata  (head_wdata),
      .cfg_we      (cfg_we),
      .cfg_limit   (cfg_limit),
      .cfg_thresh  (cfg_thresh),
      .sig_clr     (sig_clr),
      .proc_ack    (proc_ack),
      .ovf_release (ovf_release),
      .tail        (tail_o),
      .occ         (occ_o),
      .limit       (limit_cur),
      .ovf_used    (ovf_used_o),
      .sig         (sig_o),
      .irq         (msg_irq)
   );

endmodule

// File: rtl/mq_receiver_chk.sv
module mq_receiver_chk #(
   parameter int  DATA_W     = 64,
   parameter int  MSG_WORDS  = 4,
   parameter int  NORM_SLOTS = 4080,
   parameter int  OVF_SLOTS  = 16,
   parameter int  NODE_W     = 11,
   parameter int  MEM_AW     = 16,
   localparam int NORM_W     = $clog2(NORM_SLOTS),
   localparam int OCC_W      = $clog2(NORM_SLOTS + 1),
   localparam int OVF_CW     = (OVF_SLOTS > 0) ? $clog2(OVF_SLOTS + 1) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NODE_W-1:0] node_id,
   input logic              pkt_valid,
   input logic              pkt_ready,
   input logic [NODE_W-1:0] pkt_node,
   input logic              resp_valid,
   input logic              resp_nack,
   input logic              mem_we,
   input logic              sig_clr,
   input logic              proc_ack,
   input logic              msg_irq,
   input logic              sig_o,
   input logic [NORM_W-1:0] tail_o,
   input logic [OCC_W-1:0]  occ_o,
   input logic [OVF_CW-1:0] ovf_used_o
);

   localparam logic [NORM_W-1:0] LAST_IDX = NORM_W'(NORM_SLOTS - 1);

   // R2
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !pkt_ready);

   // R3
   tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_o != $past(tail_o)) |->
      (tail_o == (($past(tail_o) == LAST_IDX) ? '0 : $past(tail_o) + 1'b1)));

   // R4
   accept_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_nack) |-> $past(mem_we));

   // R5
   foreign_node_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_ready && (pkt_node != node_id)) |=> (resp_valid && resp_nack));

   // R7
   spare_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_used_o <= OVF_CW'(OVF_SLOTS));

   // R8
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_o <= OCC_W'(NORM_SLOTS));

   // R9
   sig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_o && !sig_clr) |=> sig_o);

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_irq && !proc_ack) |=> msg_irq);

endmodule

bind mq_receiver mq_receiver_chk #(
   .DATA_W     (DATA_W),
   .MSG_WORDS  (MSG_WORDS),
   .NORM_SLOTS (NORM_SLOTS),
   .OVF_SLOTS  (OVF_SLOTS),
   .NODE_W     (NODE_W),
   .MEM_AW     (MEM_AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .node_id    (node_id),
   .pkt_valid  (pkt_valid),
   .pkt_ready  (pkt_ready),
   .pkt_node   (pkt_node),
   .resp_valid (resp_valid),
   .resp_nack  (resp_nack),
   .mem_we     (mem_we),
   .sig_clr    (sig_clr),
   .proc_ack   (proc_ack),
   .msg_irq    (msg_irq),
   .sig_o      (sig_o),
   .tail_o     (tail_o),
   .occ_o      (occ_o),
   .ovf_used_o (ovf_used_o)
);

// File: tb/mq_receiver_tb.sv
`timescale 1ns/1ps
module mq_receiver_tb;

   localparam int DW    = 16;
   localparam int WORDS = 4;
   localparam int NS    = 12;
   localparam int OS    = 2;
   localparam int NW    = 6;
   localparam int AW    = 12;
   localparam int BASE  = 'h100;
   localparam int HW    = $clog2(NS);
   localparam int OCW   = $clog2(NS + 1);
   localparam int OVW   = $clog2(OS + 1);
   localparam logic [NW-1:0] MY_NODE = 6'd9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              pkt_valid = 1'b0, pkt_err = 1'b0;
   logic [NW-1:0]     pkt_node = '0;
   logic [DW*WORDS-1:0] pkt_data = '0;
   logic              head_we = 1'b0, cfg_we = 1'b0;
   logic [HW-1:0]     head_wdata = '0;
   logic [OCW-1:0]    cfg_limit = '0, cfg_thresh = '0;
   logic              sig_clr = 1'b0, proc_ack = 1'b0, ovf_release = 1'b0;
   logic              pkt_ready, resp_valid, resp_nack, mem_we, msg_irq, sig_o;
   logic [AW-1:0]     mem_addr;
   logic [DW-1:0]     mem_wdata;
   logic [HW-1:0]     tail_o;
   logic [OCW-1:0]    occ_o;
   logic [OVW-1:0]    ovf_used_o;

   mq_receiver #(
      .DATA_W(DW), .MSG_WORDS(WORDS), .NORM_SLOTS(NS), .OVF_SLOTS(OS),
      .NODE_W(NW), .MEM_AW(AW), .BASE_ADDR(BASE), .THRESH_RST(0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .node_id(MY_NODE),
      .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_node(pkt_node),
      .pkt_err(pkt_err), .pkt_data(pkt_data),
      .resp_valid(resp_valid), .resp_nack(resp_nack),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .head_we(head_we), .head_wdata(head_wdata),
      .cfg_we(cfg_we), .cfg_limit(cfg_limit), .cfg_thresh(cfg_thresh),
      .sig_clr(sig_clr), .proc_ack(proc_ack), .ovf_release(ovf_release),
      .msg_irq(msg_irq), .sig_o(sig_o), .tail_o(tail_o), .occ_o(occ_o),
      .ovf_used_o(ovf_used_o)
   );

   int n_checks = 0;
   int n_errors = 0;

   task automatic check(input string tag, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_errors++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          m_beat, m_slot, m_kind;
   int          m_tail, m_head, m_occ, m_ovf, m_limit, m_thresh;
   bit          m_sig, m_irq, m_rv, m_rn;
   int          m_words [WORDS];

   always @(negedge clk) begin
      if (!rst_n) begin
         m_beat = -1; m_slot = 0; m_kind = 0;
         m_tail = 0; m_head = 0; m_occ = 0; m_ovf = 0;
         m_limit = NS; m_thresh = 0;
         m_sig = 0; m_irq = 0; m_rv = 0; m_rn = 0;
      end else begin
         bit commit, nrv, nrn;
         int freed, occ_n;
         // compare this cycle's outputs (R2, R3, R4, R7, R8, R9, R10)
         check("R2 ready", int'(pkt_ready), (m_beat < 0) ? 1 : 0);
         check("R2 mem_we", int'(mem_we), (m_beat >= 0) ? 1 : 0);
         if (m_beat >= 0) begin
            check("R2 addr", int'(mem_addr), BASE + m_slot * WORDS + m_beat);
            check("R2 data", int'(mem_wdata), m_words[m_beat]);
         end
         check("R4 resp_valid", int'(resp_valid), int'(m_rv));
         if (m_rv) check("R4 resp_nack", int'(resp_nack), int'(m_rn));
         check("R3 tail", int'(tail_o), m_tail);
         check("R8 occ", int'(occ_o), m_occ);
         check("R7 ovf_used", int'(ovf_used_o), m_ovf);
         check("R9 sig", int'(sig_o), int'(m_sig));
         check("R10 irq", int'(msg_irq), int'(m_irq));
         // advance the model over the coming edge
         commit = (m_beat == WORDS - 1);
         nrv = 0; nrn = 0;
         if (m_beat >= 0) begin
            if (commit) begin
               nrv = 1;
            end
         end else if (pkt_valid) begin
            if (pkt_node != MY_NODE) begin
               nrv = 1; nrn = 1;
            end else if (m_occ < m_limit) begin
               m_kind = 1; m_slot = m_tail;
            end else if (pkt_err && m_ovf < OS) begin
               m_kind = 2; m_slot = NS + m_ovf;
            end else begin
               nrv = 1; nrn = 1;
            end
            if (!nrv) begin
               for (int w = 0; w < WORDS; w++) m_words[w] = int'(pkt_data[w*DW +: DW]);
            end
         end
         freed = head_we ? ((int'(head_wdata) - m_head + NS) % NS) : 0;
         occ_n = m_occ - freed + ((commit && m_kind == 1) ? 1 : 0);
         if (commit && m_kind == 1) begin
            m_tail = (m_tail + 1) % NS;
            if (m_thresh != 0 && occ_n >= m_thresh) m_sig = 1;
            else if (sig_clr) m_sig = 0;
         end else if (sig_clr) begin
            m_sig = 0;
         end
         if (commit) m_irq = 1;
         else if (proc_ack) m_irq = 0;
         m_ovf = (ovf_release ? 0 : m_ovf) + ((commit && m_kind == 2) ? 1 : 0);
         m_occ = occ_n;
         if (head_we) m_head = int'(head_wdata);
         if (cfg_we) begin
            m_limit = (int'(cfg_limit) > NS) ? NS : int'(cfg_limit);
            m_thresh = int'(cfg_thresh);
         end
         if (m_beat >= 0) m_beat = commit ? -1 : m_beat + 1;
         else if (pkt_valid && !nrv) m_beat = 0;
         m_rv = nrv; m_rn = nrn;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic send(input logic [NW-1:0] node, input bit err, input int seed,
                       output bit nacked);
      @(posedge clk); #1;
      pkt_valid = 1'b1; pkt_node = node; pkt_err = err;
      for (int w = 0; w < WORDS; w++) pkt_data[w*DW +: DW] = DW'(seed * 37 + w * 5 + 1);
      @(negedge clk);
      while (!pkt_ready) @(negedge clk);
      @(posedge clk); #1;
      pkt_valid = 1'b0;
      @(negedge clk);
      while (!resp_valid) @(negedge clk);
      nacked = resp_nack;
   endtask

   // which: 0 head write, 1 signal clear, 2 acknowledge, 3 spare release
   task automatic strobe(input int which, input int value);
      @(posedge clk); #1;
      case (which)
         0: begin head_we = 1'b1; head_wdata = HW'(value); end
         1: sig_clr = 1'b1;
         2: proc_ack = 1'b1;
         default: ovf_release = 1'b1;
      endcase
      @(posedge clk); #1;
      head_we = 1'b0; sig_clr = 1'b0; proc_ack = 1'b0; ovf_release = 1'b0;
   endtask

   // Drive a strobe for exactly the cycle of the final word write.
   task automatic strobe_at_commit(input int which, input int value);
      @(negedge clk);
      while (!(mem_we && mem_addr[1:0] == 2'd2)) @(negedge clk);
      strobe(which, value);
   endtask

   task automatic configure(input int lim, input int thr);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_limit = OCW'(lim); cfg_thresh = OCW'(thr);
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      bit nk;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ready", int'(pkt_ready), 1);
      check("R1 mem_we", int'(mem_we), 0);
      check("R1 resp", int'(resp_valid), 0);
      check("R1 irq", int'(msg_irq), 0);
      check("R1 sig", int'(sig_o), 0);
      check("R1 tail", int'(tail_o), 0);
      check("R1 occ", int'(occ_o), 0);
      check("R1 ovf", int'(ovf_used_o), 0);

      configure(NS, 5);
      for (int i = 0; i < 3; i++) begin
         send(MY_NODE, 1'b0, i, nk);
         check("R4 accept", int'(nk), 0);
      end
      check("R3 tail after three", int'(tail_o), 3);
      strobe(2, 0);
      check("R10 ack clears", int'(msg_irq), 0);

      send(6'd3, 1'b0, 50, nk);
      check("R5 foreign nack", int'(nk), 1);
      check("R5 tail kept", int'(tail_o), 3);

      // head write on the closing edge of a store
      fork
         send(MY_NODE, 1'b0, 60, nk);
         strobe_at_commit(0, 2);
      join
      check("R8 same-edge occ", int'(occ_o), 2);

      for (int i = 0; i < 3; i++) send(MY_NODE, 1'b0, 70 + i, nk);
      check("R9 threshold sets", int'(sig_o), 1);
      fork
         send(MY_NODE, 1'b0, 80, nk);
         strobe_at_commit(1, 0);
      join
      check("R9 set wins over clear", int'(sig_o), 1);
      strobe(1, 0);
      check("R9 clear", int'(sig_o), 0);

      for (int i = 0; i < 6; i++) begin
         send(MY_NODE, 1'b0, 90 + i, nk);
         check("R4 fill accept", int'(nk), 0);
      end
      check("R3 wrapped tail", int'(tail_o), 2);
      check("R8 full occ", int'(occ_o), NS);
      send(MY_NODE, 1'b0, 100, nk);
      check("R6 full nack", int'(nk), 1);
      check("R6 tail kept", int'(tail_o), 2);

      send(MY_NODE, 1'b1, 110, nk);
      check("R7 spare accept", int'(nk), 0);
      check("R7 spare count", int'(ovf_used_o), 1);
      send(MY_NODE, 1'b1, 111, nk);
      check("R7 second spare", int'(nk), 0);
      send(MY_NODE, 1'b1, 112, nk);
      check("R7 spare full nack", int'(nk), 1);
      strobe(3, 0);
      check("R7 release", int'(ovf_used_o), 0);

      configure(15, 5);
      send(MY_NODE, 1'b0, 120, nk);
      check("R11 limit clamped", int'(nk), 1);

      strobe(0, 8);
      check("R8 head frees six", int'(occ_o), 6);
      strobe(0, 2);
      check("R8 head frees rest", int'(occ_o), 0);

      configure(2, 0);
      send(MY_NODE, 1'b0, 130, nk);
      check("R11 limit two first", int'(nk), 0);
      fork
         send(MY_NODE, 1'b0, 131, nk);
         strobe_at_commit(2, 0);
      join
      check("R11 limit two second", int'(nk), 0);
      check("R10 store wins over ack", int'(msg_irq), 1);
      send(MY_NODE, 1'b0, 132, nk);
      check("R11 limit two reached", int'(nk), 1);
      strobe(2, 0);
      check("R10 ack", int'(msg_irq), 0);

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule